// File: doc/BRIEF.md
# Dual Chip-Select SPI Master with Memory-Window Data Path

This block drives an SPI bus for two attached devices, one device per chip select, and moves data only in one direction at a time. A host talks to it over a simple request/ready bus. That bus carries two kinds of traffic. Register accesses configure the block. Window accesses move data. A window behaves like a FIFO port, so the offset inside it does not matter. The width of the access decides how many bytes cross the SPI wires. A window write shifts its bytes out on MOSI, and a window read shifts bytes in from MISO.

Each chip select has its own control word with these fields:
- a user-mode field, which releases or asserts the chip select together with the stop bit,
- a stop bit,
- a clock-polarity choice between mode 0 and mode 3,
- a bit-order choice,
- a clock-divider code.

A shared interrupt register records two fault conditions. The first is an access that could not be carried out. The second is a write into a window whose write permission is off. Each condition has an enable, and together they drive one interrupt line.

The host address splits into regions by its top two bits: 00 for registers, 01 for window 0, 10 for window 1, and 11 for an unmapped region that reads as zero. Register offsets are the low eight address bits.
- 0x00 is the configuration word. Its bit 16+i enables writes to window i.
- 0x08 is the interrupt register.
- 0x10 is the control word for chip select 0, and 0x14 is the control word for chip select 1.

Top module: `spi_win_master`

## Requirements
- R1: After reset, both chip-select outputs are high and SCK is low. The interrupt and ready outputs are low. The control words read 0x0000_0004, and the configuration and interrupt registers read zero.
- R2: A chip select drives low exactly when its control bits 1:0 are both 1 and its bit 2 (stop) is 0. Otherwise it is high.
- R3: A window write of size code 0, 1 or 2 sends 1, 2 or 4 bytes on MOSI. Size code 0 is a byte, 1 a halfword and 2 a word. Write data bits 7:0 go first, then 15:8, and so on. The address bits below the region field have no effect.
- R4: Bits go out and come in MSB first when control bit 5 is 0, and LSB first when it is 1.
- R5: Control bit 4 selects mode 3 when set, where SCK idles high, and mode 0 when clear, where SCK idles low. In both modes MISO is sampled on the rising SCK edge and MOSI changes only on a falling edge. SCK is back at its idle level when a byte ends.
- R6: With divider code N in control bits 11:8, every SCK high phase and every low phase lasts N+1 clock cycles.
- R7: A window read returns the received bytes right-justified, with the first byte in bits 7:0. MOSI stays low during a read.
- R8: A window access holds ready low until its last byte has finished shifting. Ready is a single-cycle pulse.
- R9: Some window accesses complete with no SCK activity, return zero, and set interrupt bit 10 (abort): any window access while the target chip select is released, any misaligned access, and size code 3.
- R10: A window write while configuration bit 16+i is 0 is discarded without SCK activity and sets interrupt bit 9 (protect violation).
- R11: The interrupt output is high when bit 10 and its enable bit 2 are both set, or when bit 9 and its enable bit 1 are both set. Writing 1 to a status bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, held until ready |
| host_we | input | 1 | 1 for write, 0 for read |
| host_addr | input | ADDR_W | Byte address; top two bits pick region |
| host_size | input | 2 | Access width code: 0 byte, 1 halfword, 2 word |
| host_wdata | input | 32 | Write data, right-justified |
| host_rdata | output | 32 | Read data, valid with ready |
| host_ready | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Interrupt request |
| spi_sck | output | 1 | SPI serial clock |
| spi_mosi | output | 1 | Serial data toward devices |
| spi_miso | input | 1 | Serial data from devices |
| spi_cs_n | output | 2 | Active-low chip selects, one per device |

## Verification
Four properties are checked on every cycle:
- the ready pulse lasts one cycle,
- MOSI is stable at each sampling edge of SCK,
- a byte is only shifted while some chip select is low,
- SCK is at the target's idle level when a byte finishes.

The bench's scenarios show the rest. These are the bit order on the wire, the number of bytes per access width, the length of the divider phases, the assembly of read data, and the fault paths with their interrupt gating and clearing.

// File: rtl/spi_win_pkg.sv
package spi_win_pkg;

    localparam int NUM_CS = 2;
    localparam int DIV_W  = 4;

    localparam logic [7:0] OFS_CFG   = 8'h00;
    localparam logic [7:0] OFS_IRQ   = 8'h08;
    localparam logic [7:0] OFS_CTRL0 = 8'h10;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             lsb;
        logic             mode3;
        logic             stop;
        logic [1:0]       umode;
    } cs_ctrl_t;

    localparam cs_ctrl_t CTRL_RESET = '{div: '0, lsb: 1'b0, mode3: 1'b0,
                                        stop: 1'b1, umode: 2'b00};

    typedef enum logic [1:0] {SEQ_IDLE, SEQ_RUN, SEQ_DONE} seq_state_e;

    function automatic cs_ctrl_t ctrl_from_word(input logic [31:0] w);
        cs_ctrl_t c;
        c.div   = w[8 +: DIV_W];
        c.lsb   = w[5];
        c.mode3 = w[4];
        c.stop  = w[2];
        c.umode = w[1:0];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_to_word(input cs_ctrl_t c);
        logic [31:0] w;
        w          = '0;
        w[8 +: DIV_W] = c.div;
        w[5]       = c.lsb;
        w[4]       = c.mode3;
        w[2]       = c.stop;
        w[1:0]     = c.umode;
        return w;
    endfunction

    function automatic logic bad_align(input logic [1:0] sz, input logic [1:0] lo);
        case (sz)
            2'd0:    return 1'b0;
            2'd1:    return lo[0];
            2'd2:    return |lo;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [1:0] last_byte(input logic [1:0] sz);
        case (sz)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/spi_win_regs.sv
module spi_win_regs
    import spi_win_pkg::*;
#(
    parameter int NCS = NUM_CS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr,
    input  logic [7:0]     ofs,
    input  logic [31:0]    wdata,
    output logic [31:0]    rdata,
    input  logic           set_abort,
    input  logic           set_wp,
    output cs_ctrl_t       ctrl_o [NCS],
    output logic [NCS-1:0] wr_en_o,
    output logic           irq
);
    logic sts_abort, sts_wp, en_abort, en_wp;
    logic irq_wr;

    assign irq_wr = wr && (ofs == OFS_IRQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en_o   <= '0;
            en_abort  <= 1'b0;
            en_wp     <= 1'b0;
            sts_abort <= 1'b0;
            sts_wp    <= 1'b0;
        end else begin
            if (wr && ofs == OFS_CFG) wr_en_o <= wdata[16 +: NCS];
            if (irq_wr) begin
                en_abort <= wdata[2];
                en_wp    <= wdata[1];
            end
            sts_abort <= set_abort | (sts_abort & ~(irq_wr & wdata[10]));
            sts_wp    <= set_wp    | (sts_wp    & ~(irq_wr & wdata[9]));
        end
    end

    always_ff @(posedge clk) begin
        for (int g = 0; g < NCS; g++) begin
            if (rst)
                ctrl_o[g] <= CTRL_RESET;
            else if (wr && ofs == OFS_CTRL0 + 8'(4 * g))
                ctrl_o[g] <= ctrl_from_word(wdata);
        end
    end

    always_comb begin
        rdata = '0;
        if (ofs == OFS_CFG) rdata[16 +: NCS] = wr_en_o;
        if (ofs == OFS_IRQ) begin
            rdata[10] = sts_abort;
            rdata[9]  = sts_wp;
            rdata[2]  = en_abort;
            rdata[1]  = en_wp;
        end
        for (int g = 0; g < NCS; g++)
            if (ofs == OFS_CTRL0 + 8'(4 * g)) rdata = ctrl_to_word(ctrl_o[g]);
    end

    assign irq = (sts_abort & en_abort) | (sts_wp & en_wp);

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
    import spi_win_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             wr_mode,
    input  logic             lsb,
    input  logic             mode3,
    input  logic [DIV_W-1:0] div,
    input  logic [7:0]       tx_byte,
    input  logic             idle_lvl,
    input  logic             miso,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rx_byte,
    output logic             sck,
    output logic             mosi
);
    localparam int EDGES = 16;
    localparam int K_W   = $clog2(EDGES + 1);

    logic [7:0]       sr;
    logic [K_W-1:0]   k;
    logic [DIV_W-1:0] tmr, div_q;
    logic             wr_q, lsb_q, m3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0; done <= 1'b0; sck <= 1'b0;
            sr <= '0; rx_byte <= '0; k <= '0; tmr <= '0; div_q <= '0;
            wr_q <= 1'b0; lsb_q <= 1'b0; m3_q <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                sck <= idle_lvl;
                if (start) begin
                    busy    <= 1'b1;
                    sck     <= mode3;
                    sr      <= tx_byte;
                    rx_byte <= '0;
                    k       <= '0;
                    tmr     <= div;
                    div_q   <= div;
                    wr_q    <= wr_mode;
                    lsb_q   <= lsb;
                    m3_q    <= mode3;
                end
            end else if (tmr != '0) begin
                tmr <= tmr - 1'b1;
            end else begin
                tmr <= div_q;
                if (k == K_W'(EDGES)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    sck <= ~sck;
                    k   <= k + 1'b1;
                    if (!sck)
                        rx_byte <= lsb_q ? {miso, rx_byte[7:1]} : {rx_byte[6:0], miso};
                    else if (!(m3_q && k == '0))
                        sr <= lsb_q ? (sr >> 1) : (sr << 1);
                end
            end
        end
    end

    assign mosi = busy & wr_q & (lsb_q ? sr[0] : sr[7]);

endmodule

// File: rtl/spi_win_master.sv
module spi_win_master
    import spi_win_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [1:0]        host_size,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_ready,
    output logic              irq,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);
    seq_state_e        state;
    cs_ctrl_t          ctrl [NUM_CS];
    logic [NUM_CS-1:0] cs_act, wr_en;
    logic [31:0]       reg_rdata, wbuf;
    logic [1:0]        region, idx, idx_last;
    logic              win, sel_q, sel, wr_q;
    logic              acc, is_reg, is_win, bad, prot, go, reg_wr;
    logic              set_abort, set_wp, start, last, idle_lvl;
    logic              sh_busy, sh_done;
    logic [7:0]        rx_byte, tx_byte;

    assign region = host_addr[ADDR_W-1 -: 2];
    assign is_reg = (region == 2'b00);
    assign is_win = (region == 2'b01) || (region == 2'b10);
    assign win    = region[1];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CS; gi++) begin : g_cs
            assign cs_act[gi]   = (ctrl[gi].umode == 2'b11) && !ctrl[gi].stop;
            assign spi_cs_n[gi] = ~cs_act[gi];
        end
    endgenerate

    always_comb begin
        idle_lvl = 1'b0;
        for (int i = NUM_CS - 1; i >= 0; i--)
            if (cs_act[i]) idle_lvl = ctrl[i].mode3;
    end

    assign acc       = (state == SEQ_IDLE) && host_req;
    assign reg_wr    = acc && is_reg && host_we;
    assign bad       = is_win && (bad_align(host_size, host_addr[1:0]) || !cs_act[win]);
    assign prot      = is_win && !bad && host_we && !wr_en[win];
    assign go        = acc && is_win && !bad && !prot;
    assign set_abort = acc && bad;
    assign set_wp    = acc && prot;
    assign last      = (idx == idx_last);
    assign start     = go || ((state == SEQ_RUN) && sh_done && !last);
    assign tx_byte   = go ? host_wdata[7:0] : wbuf[15:8];
    assign sel       = go ? win : sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE; host_rdata <= '0; wbuf <= '0;
            idx <= '0; idx_last <= '0; sel_q <= 1'b0; wr_q <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: if (acc) begin
                    if (go) begin
                        state      <= SEQ_RUN;
                        sel_q      <= win;
                        wbuf       <= host_wdata;
                        idx        <= '0;
                        idx_last   <= last_byte(host_size);
                        wr_q       <= host_we;
                        host_rdata <= '0;
                    end else begin
                        state      <= SEQ_DONE;
                        host_rdata <= is_reg ? reg_rdata : '0;
                    end
                end
                SEQ_RUN: if (sh_done) begin
                    if (!wr_q) host_rdata[{idx, 3'b000} +: 8] <= rx_byte;
                    wbuf <= wbuf >> 8;
                    if (last) state <= SEQ_DONE;
                    else      idx   <= idx + 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign host_ready = (state == SEQ_DONE);

    spi_win_regs #(.NCS(NUM_CS)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .ofs(host_addr[7:0]),
        .wdata(host_wdata), .rdata(reg_rdata),
        .set_abort(set_abort), .set_wp(set_wp),
        .ctrl_o(ctrl), .wr_en_o(wr_en), .irq(irq)
    );

    spi_byte_shifter u_shift (
        .clk(clk), .rst(rst), .start(start),
        .wr_mode(go ? host_we : wr_q),
        .lsb(ctrl[sel].lsb), .mode3(ctrl[sel].mode3), .div(ctrl[sel].div),
        .tx_byte(tx_byte), .idle_lvl(idle_lvl), .miso(spi_miso),
        .busy(sh_busy), .done(sh_done), .rx_byte(rx_byte),
        .sck(spi_sck), .mosi(spi_mosi)
    );

endmodule

// File: rtl/spi_win_chk.sv
module spi_win_chk
    import spi_win_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              host_ready,
    input logic              spi_sck,
    input logic              spi_mosi,
    input logic [NUM_CS-1:0] spi_cs_n,
    input logic              sh_busy,
    input logic              idle_lvl
);
    // R8: completion is a single-cycle pulse
    a_r8_ready_one_cycle: assert property (@(posedge clk) disable iff (rst)
        host_ready |=> !host_ready);

    // R5: data line holds still across every sampling edge
    a_r5_mosi_held_on_sample: assert property (@(posedge clk) disable iff (rst)
        ($past(sh_busy) && $rose(spi_sck)) |-> $stable(spi_mosi));

    // R2: bytes only move while some device is selected
    a_r2_busy_needs_cs: assert property (@(posedge clk) disable iff (rst)
        sh_busy |-> (spi_cs_n != '1));

    // R5: clock returns to the selected idle level after each byte
    a_r5_sck_idle_after_byte: assert property (@(posedge clk) disable iff (rst)
        ($fell(sh_busy) && $countones(~spi_cs_n) == 1) |-> (spi_sck == idle_lvl));
endmodule

bind spi_win_master spi_win_chk u_chk (
    .clk(clk), .rst(rst), .host_ready(host_ready), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .sh_busy(sh_busy),
    .idle_lvl(idle_lvl)
);

// File: tb/sim_spi_win_master.sv
`timescale 1ns/1ps
module sim_spi_win_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [15:0] host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ready, irq, spi_sck, spi_mosi, spi_miso;
    logic [1:0]  spi_cs_n;

    int checks = 0, errors = 0;
    int rises = 0, highs = 0, mosi_hi = 0, rbase = 0;
    logic [31:0] cap = '0, rd_stream = '0;

    always #2 clk = ~clk;

    spi_win_master u0 (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ready(host_ready), .irq(irq),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    // bench-side SPI device: samples MOSI and advances MISO on rising SCK
    always @(posedge spi_sck) if (spi_cs_n != 2'b11) begin
        cap   <= {cap[30:0], spi_mosi};
        rises <= rises + 1;
    end
    always @(negedge clk) begin
        if (spi_sck)  highs   <= highs + 1;
        if (spi_mosi) mosi_hi <= mosi_hi + 1;
    end
    assign spi_miso = ((rises - rbase) < 32 && (rises - rbase) >= 0)
                      ? rd_stream[31 - (rises - rbase)] : 1'b0;

    // cs, mode3, lsb, div[3:0], size[1:0], data[31:0]
    localparam logic [40:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 32'h0000_00A5},
        {1'b0, 1'b1, 1'b0, 4'd1, 2'd1, 32'h0000_1234},
        {1'b1, 1'b0, 1'b1, 4'd2, 2'd2, 32'hCAFE_0137},
        {1'b1, 1'b1, 1'b1, 4'd0, 2'd0, 32'h0000_0080},
        {1'b0, 1'b0, 1'b1, 4'd3, 2'd1, 32'h0000_0F01},
        {1'b1, 1'b1, 1'b0, 4'd0, 2'd2, 32'hDEAD_BEEF}
    };

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7 - i];
        return r;
    endfunction

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [15:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd);
        int n;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_size = sz; host_wdata = wd;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!host_ready && n < 5000);
        if (n >= 5000) begin
            checks++; errors++;
            $display("FAIL R8: actual no ready expected ready (watchdog)");
        end
        rd = host_rdata;
        host_req = 1'b0;
        @(negedge clk);
        check("R8", {31'b0, host_ready}, 32'd0);
    endtask

    task automatic wr_reg(input logic [7:0] ofs, input logic [31:0] d);
        logic [31:0] dummy;
        access(1'b1, {8'h00, ofs}, 2'd2, d, dummy);
    endtask

    task automatic rd_reg(input logic [7:0] ofs, output logic [31:0] d);
        access(1'b0, {8'h00, ofs}, 2'd2, 32'h0, d);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
        $finish;
    end

    initial begin
        logic [31:0] r, exp_cap, mask, stream;
        int r0, h0, m0, nb;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1", {30'b0, spi_cs_n}, 32'd3);
        check("R1", {31'b0, spi_sck}, 32'd0);
        check("R1", {31'b0, irq}, 32'd0);
        check("R1", {31'b0, host_ready}, 32'd0);
        rd_reg(8'h10, r); check("R1", r, 32'h4);
        rd_reg(8'h14, r); check("R1", r, 32'h4);
        rd_reg(8'h08, r); check("R1", r, 32'h0);
        rd_reg(8'h00, r); check("R1", r, 32'h0);

        wr_reg(8'h00, 32'h0003_0000);

        foreach (VEC[v]) begin
            logic c, m3, lsb;
            logic [3:0] dv;
            logic [1:0] sz;
            logic [31:0] dat;
            logic [15:0] base;
            {c, m3, lsb, dv, sz, dat} = VEC[v];
            nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
            mask = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
            base = c ? 16'h8000 : 16'h4000;
            wr_reg(c ? 8'h10 : 8'h14, 32'h4);
            wr_reg(c ? 8'h14 : 8'h10, {20'b0, dv, 2'b0, lsb, m3, 4'b0011});
            check("R2", {30'b0, spi_cs_n}, c ? 32'd1 : 32'd2);
            check("R5", {31'b0, spi_sck}, {31'b0, m3});

            // write: offset inside window chosen aligned but non-zero (R3)
            exp_cap = '0;
            for (int i = 0; i < nb; i++) begin
                logic [7:0] b;
                b = dat[8 * i +: 8];
                exp_cap = (exp_cap << 8) | {24'b0, lsb ? rev8(b) : b};
            end
            r0 = rises; h0 = highs;
            access(1'b1, base | ((sz == 0) ? 16'h0043 : (sz == 1) ? 16'h0042 : 16'h0044),
                   sz, dat, r);
            check("R3", rises - r0, 8 * nb);
            check(lsb ? "R4" : "R3", cap & ((nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nb)) - 1)),
                  exp_cap);
            if (!m3) check("R6", highs - h0, 8 * nb * (dv + 1));
            check("R5", {31'b0, spi_sck}, {31'b0, m3});

            // read the same pattern back from the device side
            stream = '0;
            for (int i = 0; i < nb; i++) begin
                logic [7:0] b;
                b = dat[8 * i +: 8];
                stream[31 - 8 * i -: 8] = lsb ? rev8(b) : b;
            end
            rd_stream = stream;
            rbase = rises; r0 = rises; m0 = mosi_hi;
            access(1'b0, base | 16'h0100, sz, 32'hFFFF_FFFF, r);
            check(lsb ? "R4" : "R7", r, dat & mask);
            check("R7", mosi_hi - m0, 0);
            check("R8", rises - r0, 8 * nb);
        end

        // R9: read while chip select released
        wr_reg(8'h10, 32'h7);
        wr_reg(8'h14, 32'h4);
        r0 = rises;
        access(1'b0, 16'h4000, 2'd0, 32'h0, r);
        check("R9", r, 32'h0);
        check("R9", rises - r0, 0);
        rd_reg(8'h08, r); check("R9", r, 32'h400);
        check("R11", {31'b0, irq}, 32'd0);
        wr_reg(8'h08, 32'h4);
        check("R11", {31'b0, irq}, 32'd1);
        wr_reg(8'h08, 32'h404);
        check("R11", {31'b0, irq}, 32'd0);
        rd_reg(8'h08, r); check("R11", r, 32'h4);

        // R9: misaligned halfword on an active chip select
        wr_reg(8'h10, 32'h3);
        r0 = rises;
        access(1'b0, 16'h4001, 2'd1, 32'h0, r);
        check("R9", r, 32'h0);
        check("R9", rises - r0, 0);
        check("R9", {31'b0, irq}, 32'd1);
        wr_reg(8'h08, 32'h400);

        // R10: write with window 0 write permission cleared
        wr_reg(8'h00, 32'h0002_0000);
        r0 = rises;
        access(1'b1, 16'h4000, 2'd2, 32'h1234_5678, r);
        check("R10", rises - r0, 0);
        rd_reg(8'h08, r); check("R10", r, 32'h200);
        check("R11", {31'b0, irq}, 32'd0);
        wr_reg(8'h08, 32'h2);
        check("R11", {31'b0, irq}, 32'd1);
        wr_reg(8'h08, 32'h200);
        check("R11", {31'b0, irq}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule